// File: doc/BRIEF.md
# Selectable Page Replacement Tracker

This block keeps track of which virtual page numbers currently sit in a small, fixed set of physical frames belonging to one process. Each incoming page reference is looked up against the frames. A resident page is reported as a hit, together with the frame that holds it. A page that is not resident is reported as a fault. The page is then placed into a frame: either the lowest-numbered empty frame, or a victim chosen by the active replacement policy. On an eviction the displaced page is reported.

Three eviction policies share one frame table: least recently used, first-in first-out, and least frequently used. The frequency policy keeps a saturating use count per frame. When two frames have the same count, it removes the page that was loaded earliest. The policy is sampled only on reset or on a synchronous clear, so a running sequence cannot be disturbed by a change on the select input. A running fault count covers every non-resident reference, including the compulsory fills of empty frames. Loading page contents and address translation belong to the surrounding system.

Top module: `page_repl_tracker`

## Requirements
- R1: After reset, or in the cycle after `clear` is high, all frames are empty, `fault_count` is 0 and `out_valid` is low.
- R2: A reference accepted at a clock edge (`ref_valid` high, `clear` low) raises `out_valid` for exactly the following cycle. In that cycle exactly one of `out_hit` and `out_fault` is high. Without an accepted reference, `out_valid`, `out_hit`, `out_fault` and `evict_valid` are low.
- R3: A reference to a resident page reports a hit and the index of the frame holding it. It reports `evict_valid` low and leaves `fault_count` unchanged.
- R4: A reference to a non-resident page reports a fault and adds 1 to `fault_count`, whether or not a frame was empty. While any frame is empty, the page goes into the lowest-numbered empty frame and `evict_valid` stays low.
- R5: With policy code 2'b00 (and likewise 2'b11), a fault on a full table evicts the frame whose page was referenced least recently. Both hits and fills count as references.
- R6: With policy code 2'b01, a fault on a full table evicts the frame whose page was loaded earliest. Hits do not change this order.
- R7: With policy code 2'b10, a fault on a full table evicts the frame with the smallest use count. Ties go to the page loaded earliest. The count is set to 1 on a fill and rises by 1 on each hit, saturating at 2^CNT_W-1.
- R8: The policy select is sampled only on reset or clear. Changing it at any other time has no effect on evictions.
- R9: When `clear` and `ref_valid` are high in the same cycle, the clear wins and the reference is dropped. No result is reported, and the frames are left empty.
- R10: For the reference sequence 4,3,6,1,5,1,3,6,4,2,2,3 starting from empty frames, `fault_count` ends at 7 under least recently used, 8 under first-in first-out and 7 under least frequently used.
- R11: On an eviction, `evict_valid` is high and `evict_page` is the page that the reported frame held before the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous clear of frames and counters; samples `policy` |
| policy | input | 2 | Policy select: 00 LRU, 01 FIFO, 10 LFU, 11 LRU |
| ref_valid | input | 1 | Page reference strobe |
| ref_page | input | PAGE_W | Referenced virtual page number |
| out_valid | output | 1 | Result of the previous cycle's reference is present |
| out_hit | output | 1 | Reference was resident |
| out_fault | output | 1 | Reference was not resident |
| out_frame | output | IDX_W | Frame that holds the page after the reference |
| evict_valid | output | 1 | A resident page was displaced |
| evict_page | output | PAGE_W | Page that was displaced |
| fault_count | output | FCNT_W | Running number of faults since reset or clear |

## Verification
Two functions can land in the same cycle: a synchronous clear and an accepted reference. The bench first fills the frames, then raises `clear` and `ref_valid` together, naming a page that was resident. It judges the outcome one cycle later: no result strobe and a zero fault count. A second reference to that same page must then show a fault into frame 0 with no eviction. A fault and the fault-count step also coincide on every miss. Each one is compared against a timestamp-based reference model across sweeps of all four policy codes over many pseudo-random sequences on small page alphabets.

// File: rtl/repl_pkg.sv
// Package: shared types for the page replacement tracker.
// Assumes: the policy code is two bits wide; code 3 behaves as LRU.
package repl_pkg;
    typedef enum logic [1:0] {
        POL_LRU     = 2'b00,
        POL_FIFO    = 2'b01,
        POL_LFU     = 2'b10,
        POL_LRU_ALT = 2'b11
    } repl_pol_e;
endpackage

// File: rtl/repl_match.sv
// Module: repl_match
// Compares a referenced page against every frame. Reports whether any
// valid frame holds it, and the lowest such frame index.
// Assumes: at most one valid frame holds a given page.
module repl_match #(
    parameter int NUM_FRAMES = 4,
    parameter int PAGE_W     = 8,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic [NUM_FRAMES-1:0]             frame_valid,
    input  logic [NUM_FRAMES-1:0][PAGE_W-1:0] frame_page,
    input  logic [PAGE_W-1:0]                 ref_page,
    output logic                              hit,
    output logic [IDX_W-1:0]                  hit_idx
);
    logic [NUM_FRAMES-1:0] eq;

    // per-frame compare
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
        assign eq[g] = frame_valid[g] && (frame_page[g] == ref_page);
    end

    assign hit = |eq;

    // priority encode, lowest index wins
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/repl_rank_upd.sv
// Module: repl_rank_upd
// Move-to-front update of a rank permutation. The selected frame
// becomes rank 0, and every frame ranked below its old rank moves
// down by one.
// Assumes: valid frames hold distinct ranks. Empty frames hold the
// oldest rank and are passed that value as sel_rank.
module repl_rank_upd #(
    parameter int NUM_FRAMES = 4,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic                             en,
    input  logic [IDX_W-1:0]                 sel,
    input  logic [IDX_W-1:0]                 sel_rank,
    input  logic [NUM_FRAMES-1:0][IDX_W-1:0] rank_in,
    output logic [NUM_FRAMES-1:0][IDX_W-1:0] rank_out
);
    // one update lane per frame
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_lane
        always_comb begin
            rank_out[g] = rank_in[g];
            if (en) begin
                if (sel == IDX_W'(g))
                    rank_out[g] = '0;
                else if (rank_in[g] < sel_rank)
                    rank_out[g] = rank_in[g] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/repl_victim.sv
// Module: repl_victim
// Chooses the frame that a faulting page goes into. This is the lowest
// empty frame if one exists; otherwise the policy decides. LRU and FIFO
// take the frame holding the oldest rank. LFU takes the smallest use
// count, with ties going to the earliest loaded frame.
// Assumes: ranks of valid frames form a permutation when all are valid.
module repl_victim #(
    parameter int NUM_FRAMES = 4,
    parameter int CNT_W      = 3,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  repl_pkg::repl_pol_e               pol,
    input  logic [NUM_FRAMES-1:0]             frame_valid,
    input  logic [NUM_FRAMES-1:0][IDX_W-1:0]  lru_rank,
    input  logic [NUM_FRAMES-1:0][IDX_W-1:0]  age_rank,
    input  logic [NUM_FRAMES-1:0][CNT_W-1:0]  use_cnt,
    output logic [IDX_W-1:0]                  victim
);
    import repl_pkg::*;
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_FRAMES - 1);

    logic             found_empty;
    logic [IDX_W-1:0] empty_idx;
    logic [IDX_W-1:0] lru_idx;
    logic [IDX_W-1:0] fifo_idx;
    logic [IDX_W-1:0] lfu_idx;

    // lowest empty frame
    always_comb begin
        found_empty = 1'b0;
        empty_idx   = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (!frame_valid[i]) begin
                found_empty = 1'b1;
                empty_idx   = IDX_W'(i);
            end
        end
    end

    // frames holding the oldest recency and load rank
    always_comb begin
        lru_idx  = '0;
        fifo_idx = '0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (lru_rank[i] == OLDEST) lru_idx  = IDX_W'(i);
            if (age_rank[i] == OLDEST) fifo_idx = IDX_W'(i);
        end
    end

    // least count, ties to the earliest loaded
    always_comb begin
        lfu_idx = '0;
        for (int i = 1; i < NUM_FRAMES; i++) begin
            if ((use_cnt[i] < use_cnt[lfu_idx]) ||
                ((use_cnt[i] == use_cnt[lfu_idx]) && (age_rank[i] > age_rank[lfu_idx])))
                lfu_idx = IDX_W'(i);
        end
    end

    // final pick
    always_comb begin
        if (found_empty)
            victim = empty_idx;
        else begin
            case (pol)
                POL_FIFO: victim = fifo_idx;
                POL_LFU:  victim = lfu_idx;
                default:  victim = lru_idx;
            endcase
        end
    end
endmodule

// File: rtl/page_repl_tracker.sv
// Module: page_repl_tracker
// Tracks which pages occupy NUM_FRAMES physical frames. Reports hit or
// fault one cycle after each reference, picks a victim frame on a fault
// under a selectable policy, and counts faults.
// Assumes: NUM_FRAMES is a power of two of at least 2. Reset and clear
// are synchronous. The policy is latched only on reset or clear.
module page_repl_tracker #(
    parameter int NUM_FRAMES = 4,
    parameter int PAGE_W     = 8,
    parameter int CNT_W      = 3,
    parameter int FCNT_W     = 16,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [1:0]        policy,
    input  logic              ref_valid,
    input  logic [PAGE_W-1:0] ref_page,
    output logic              out_valid,
    output logic              out_hit,
    output logic              out_fault,
    output logic [IDX_W-1:0]  out_frame,
    output logic              evict_valid,
    output logic [PAGE_W-1:0] evict_page,
    output logic [FCNT_W-1:0] fault_count
);
    import repl_pkg::*;
    localparam logic [IDX_W-1:0] OLDEST  = IDX_W'(NUM_FRAMES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [NUM_FRAMES-1:0]             valid_q;
    logic [NUM_FRAMES-1:0][PAGE_W-1:0] page_q;
    logic [NUM_FRAMES-1:0][IDX_W-1:0]  lru_q, lru_nx;
    logic [NUM_FRAMES-1:0][IDX_W-1:0]  age_q, age_nx;
    logic [NUM_FRAMES-1:0][CNT_W-1:0]  cnt_q;
    repl_pol_e                         pol_q;

    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] victim;
    logic [IDX_W-1:0] tgt;
    logic             acc;
    logic             fill;
    logic [IDX_W-1:0] tgt_lru_rank;
    logic [IDX_W-1:0] tgt_age_rank;

    repl_match #(.NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W)) u_match (
        .frame_valid (valid_q),
        .frame_page  (page_q),
        .ref_page    (ref_page),
        .hit         (hit),
        .hit_idx     (hit_idx)
    );

    repl_victim #(.NUM_FRAMES(NUM_FRAMES), .CNT_W(CNT_W)) u_victim (
        .pol         (pol_q),
        .frame_valid (valid_q),
        .lru_rank    (lru_q),
        .age_rank    (age_q),
        .use_cnt     (cnt_q),
        .victim      (victim)
    );

    // the reference decode: which frame is touched and whether it is filled
    always_comb begin
        acc          = ref_valid && !clear;
        fill         = acc && !hit;
        tgt          = hit ? hit_idx : victim;
        tgt_lru_rank = valid_q[tgt] ? lru_q[tgt] : OLDEST;
        tgt_age_rank = valid_q[tgt] ? age_q[tgt] : OLDEST;
    end

    // recency order moves on every reference
    repl_rank_upd #(.NUM_FRAMES(NUM_FRAMES)) u_lru_upd (
        .en       (acc),
        .sel      (tgt),
        .sel_rank (tgt_lru_rank),
        .rank_in  (lru_q),
        .rank_out (lru_nx)
    );

    // load order moves only on fills
    repl_rank_upd #(.NUM_FRAMES(NUM_FRAMES)) u_age_upd (
        .en       (fill),
        .sel      (tgt),
        .sel_rank (tgt_age_rank),
        .rank_in  (age_q),
        .rank_out (age_nx)
    );

    // frame table, policy latch and result registers
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid_q     <= '0;
            page_q      <= '0;
            lru_q       <= {NUM_FRAMES{OLDEST}};
            age_q       <= {NUM_FRAMES{OLDEST}};
            cnt_q       <= '0;
            pol_q       <= repl_pol_e'(policy);
            out_valid   <= 1'b0;
            out_hit     <= 1'b0;
            out_fault   <= 1'b0;
            out_frame   <= '0;
            evict_valid <= 1'b0;
            evict_page  <= '0;
            fault_count <= '0;
        end else begin
            out_valid   <= acc;
            out_hit     <= acc && hit;
            out_fault   <= fill;
            evict_valid <= fill && valid_q[tgt];
            if (acc) begin
                out_frame    <= tgt;
                evict_page   <= page_q[tgt];
                valid_q[tgt] <= 1'b1;
                page_q[tgt]  <= ref_page;
                lru_q        <= lru_nx;
                age_q        <= age_nx;
                if (hit) begin
                    if (cnt_q[tgt] != CNT_MAX) cnt_q[tgt] <= cnt_q[tgt] + 1'b1;
                end else begin
                    cnt_q[tgt]  <= CNT_W'(1);
                    fault_count <= fault_count + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/page_repl_tracker_chk.sv
// Module: page_repl_tracker_chk
// Port-level temporal checks for page_repl_tracker, attached by bind.
// Assumes: reset is held for at least two cycles at start-up.
module page_repl_tracker_chk #(
    parameter int NUM_FRAMES = 4,
    parameter int PAGE_W     = 8,
    parameter int FCNT_W     = 16,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              ref_valid,
    input logic              out_valid,
    input logic              out_hit,
    input logic              out_fault,
    input logic              evict_valid,
    input logic [FCNT_W-1:0] fault_count
);
    // result strobe follows an accepted reference by one cycle
    assert_result_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(ref_valid && !clear && rst_n));

    // hit and fault are exclusive and exactly one is reported
    assert_hit_xor_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hit != out_fault));

    // a hit never displaces a page
    assert_hit_no_evict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> !evict_valid);

    // a hit leaves the fault count alone
    assert_hit_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hit && !$past(clear)) |-> $stable(fault_count));

    // each fault steps the count by one
    assert_fault_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> fault_count == FCNT_W'($past(fault_count) + 1'b1));

    // clear empties the result and the count
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (fault_count == '0 && !out_valid));

    // a clear in the same cycle drops the reference
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear && ref_valid) |-> !out_valid);
endmodule

bind page_repl_tracker page_repl_tracker_chk #(
    .NUM_FRAMES (NUM_FRAMES),
    .PAGE_W     (PAGE_W),
    .FCNT_W     (FCNT_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .ref_valid   (ref_valid),
    .out_valid   (out_valid),
    .out_hit     (out_hit),
    .out_fault   (out_fault),
    .evict_valid (evict_valid),
    .fault_count (fault_count)
);

// File: tb/test_page_repl_tracker.sv
`timescale 1ns/1ps
// Bench: compares the tracker against a timestamp model over every
// policy code and many pseudo-random reference streams.
module test_page_repl_tracker;
    localparam int NF  = 4;
    localparam int PW  = 8;
    localparam int CW  = 3;
    localparam int FW  = 16;
    localparam int CMX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic [1:0]    policy = 2'b00;
    logic          ref_valid = 1'b0;
    logic [PW-1:0] ref_page = '0;
    logic          out_valid, out_hit, out_fault, evict_valid;
    logic [1:0]    out_frame;
    logic [PW-1:0] evict_page;
    logic [FW-1:0] fault_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    bit m_valid [NF];
    int m_page  [NF];
    int m_last  [NF];
    int m_load  [NF];
    int m_cnt   [NF];
    int m_pol;
    int tnow;
    int exp_fc;

    always #4 clk = ~clk;

    page_repl_tracker #(.NUM_FRAMES(NF), .PAGE_W(PW), .CNT_W(CW), .FCNT_W(FW)) i_page_repl_tracker (
        .clk(clk), .rst_n(rst_n), .clear(clear), .policy(policy),
        .ref_valid(ref_valid), .ref_page(ref_page),
        .out_valid(out_valid), .out_hit(out_hit), .out_fault(out_fault),
        .out_frame(out_frame), .evict_valid(evict_valid),
        .evict_page(evict_page), .fault_count(fault_count)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic model_reset(input int p);
        for (int i = 0; i < NF; i++) begin
            m_valid[i] = 0; m_page[i] = 0; m_last[i] = 0; m_load[i] = 0; m_cnt[i] = 0;
        end
        m_pol = p; tnow = 0; exp_fc = 0;
    endtask

    // clear with a policy, then confirm the empty state (R1)
    task automatic do_clear(input int p);
        clear = 1'b1; policy = 2'(p); ref_valid = 1'b0;
        @(negedge clk);
        clear = 1'b0;
        model_reset(p);
        check("R1 out_valid after clear", int'(out_valid), 0);
        check("R1 fault_count after clear", int'(fault_count), 0);
    endtask

    // one reference, back to back with the next
    task automatic ref_step(input int pg);
        int  fr;
        bit  e_hit, e_ev;
        int  e_evp;
        string tag;
        ref_valid = 1'b1; ref_page = PW'(pg);
        e_hit = 0; e_ev = 0; e_evp = 0; fr = -1;
        for (int i = 0; i < NF; i++)
            if (m_valid[i] && m_page[i] == pg) begin e_hit = 1; fr = i; end
        if (e_hit) begin
            tag = "R3";
            m_last[fr] = tnow;
            if (m_cnt[fr] < CMX) m_cnt[fr]++;
        end else begin
            for (int i = NF - 1; i >= 0; i--) if (!m_valid[i]) fr = i;
            if (fr >= 0) tag = "R4";
            else begin
                fr = 0;
                for (int i = 1; i < NF; i++) begin
                    if (m_pol == 1) begin
                        if (m_load[i] < m_load[fr]) fr = i;
                    end else if (m_pol == 2) begin
                        if (m_cnt[i] < m_cnt[fr] || (m_cnt[i] == m_cnt[fr] && m_load[i] < m_load[fr])) fr = i;
                    end else begin
                        if (m_last[i] < m_last[fr]) fr = i;
                    end
                end
                tag = (m_pol == 1) ? "R6 R11" : (m_pol == 2) ? "R7 R11" : "R5 R11";
                e_ev = 1; e_evp = m_page[fr];
            end
            m_valid[fr] = 1; m_page[fr] = pg; m_last[fr] = tnow; m_load[fr] = tnow; m_cnt[fr] = 1;
            exp_fc++;
        end
        tnow++;
        @(negedge clk);
        check("R2 out_valid", int'(out_valid), 1);
        check({tag, " hit"}, int'(out_hit), int'(e_hit));
        check("R2 fault", int'(out_fault), int'(!e_hit));
        check({tag, " frame"}, int'(out_frame), fr);
        check({tag, " evict_valid"}, int'(evict_valid), int'(e_ev));
        if (e_ev) check("R11 evict_page", int'(evict_page), e_evp);
        check("R4 fault_count", int'(fault_count), exp_fc);
    endtask

    task automatic idle();
        ref_valid = 1'b0;
        @(negedge clk);
        check("R2 idle out_valid", int'(out_valid), 0);
        check("R2 idle evict_valid", int'(evict_valid), 0);
    endtask

    task automatic run_seq(input int p, input int exp_faults, input bit swap_pol);
        int seq [12] = '{4, 3, 6, 1, 5, 1, 3, 6, 4, 2, 2, 3};
        do_clear(p);
        if (swap_pol) policy = 2'b10;  // R8: must be ignored until the next clear
        foreach (seq[k]) ref_step(seq[k]);
        idle();
        check(swap_pol ? "R8 fault total" : "R10 fault total", int'(fault_count), exp_faults);
    endtask

    initial begin
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        check("R1 reset fault_count", int'(fault_count), 0);

        run_seq(0, 7, 1'b0);
        run_seq(1, 8, 1'b0);
        run_seq(2, 7, 1'b0);
        run_seq(3, 7, 1'b0);
        run_seq(1, 8, 1'b1);

        // R9: clear and reference in the same cycle
        do_clear(0);
        ref_step(9); ref_step(10); ref_step(11);
        clear = 1'b1; ref_valid = 1'b1; ref_page = PW'(9);
        @(negedge clk);
        clear = 1'b0; ref_valid = 1'b0;
        model_reset(0);
        check("R9 dropped out_valid", int'(out_valid), 0);
        check("R9 fault_count zero", int'(fault_count), 0);
        ref_step(9);
        check("R9 former page faults", int'(out_fault), 1);

        // near-exhaustive sweep: policies x alphabets x seeds
        lf = 32'h1234_5678;
        for (int p = 0; p < 4; p++) begin
            for (int alpha = 5; alpha <= 8; alpha++) begin
                for (int s = 0; s < 6; s++) begin
                    do_clear(p);
                    for (int k = 0; k < 150; k++) begin
                        lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
                        ref_step(int'(lf % 32'(alpha)) + 20);
                    end
                    idle();
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule